// File: doc/BRIEF.md
# Compare-Capture Timer Core

This block is the counting core of a general-purpose timer. A 32-bit up-counter advances once per prescaled tick while the timer runs. The prescaler can be bypassed or set to divide the functional clock by a power of two. When the count steps past all-ones it either wraps to zero or loads a programmable reload value. A compare register raises a match event when the count steps onto it. A capture register latches the count when a selected transition appears on an external input. The count can be written at any time, including while the timer is running.

A dedicated output pin is driven by a small state machine. The pin can produce PWM or time-stamp signals by pulsing or toggling on overflow, on match, or on both. The states are `OUT_PARK` (timer stopped, pin at the programmable idle level), `OUT_LO` (running, pin low), `OUT_HI` (running, pin high) and `OUT_PULSE` (running, pin high for one prescaled tick). The transitions are:
- Any state goes to `OUT_PARK` when run is low.
- `OUT_PARK` goes to `OUT_LO` or `OUT_HI` at start. In toggle mode the choice follows the idle level, flipped if a trigger lands on that same edge. In pulse mode the pin starts low, or goes straight to `OUT_PULSE` if a trigger lands on that edge.
- `OUT_LO` goes to `OUT_HI` on a trigger in toggle mode, and to `OUT_PULSE` on a trigger in pulse mode.
- `OUT_HI` goes to `OUT_LO` on a trigger in toggle mode.
- `OUT_PULSE` stays until the next tick. It then re-enters `OUT_PULSE` if that tick also triggers, and returns to `OUT_LO` otherwise.

Bus access, interrupt masking and clock-source selection sit outside this core. It sees only the functional clock and plain control values. Its results leave as the count, the captured value, the pin level and three single-cycle event strobes.

Top module: `gp_timer_core`

## Requirements
- R1: While reset is asserted and after it is released, with run low: count is 0, cap_val is 0, all three strobes are 0, and pin_out equals pin_idle.
- R2: While run_en is 1 the count rises by one per tick. With psc_en=0 a tick occurs every clock. With psc_en=1 a tick occurs every 2^n clocks, where n is psc_exp and values above 8 are treated as 8.
- R3: A tick at count 0xFFFFFFFF loads reload_val if reload_en is 1, and 0 otherwise. ovf_evt is high for the one clock in which the new count is first visible.
- R4: With run_en=0 and no write, the count holds and no strobe is raised.
- R5: load_en=1 loads load_val on the next edge. It takes priority over a tick and restarts the prescale phase. A write raises neither ovf_evt nor match_evt.
- R6: With cmp_en=1, a tick that moves the count onto cmp_val raises match_evt in the clock where that count is first visible. With cmp_en=0 no match is raised.
- R7: cap_sel encodes the capture transition: 00 none, 01 rising, 10 falling, 11 both. cap_pin passes through two synchronising flops. A selected transition, with cap_en=1, latches into cap_val the count shown two clocks after the pin changed, and raises cap_evt for one clock on the third edge.
- R8: With cap_en=0 or cap_sel=00, transitions on cap_pin leave cap_val unchanged and raise no cap_evt.
- R9: In pulse mode (pin_toggle=0) a trigger drives pin_out high from the edge of the event strobe for exactly 2^n clocks, one prescaled tick.
- R10: In toggle mode (pin_toggle=1) each trigger inverts pin_out on the edge of the event strobe.
- R11: The clock after run_en goes low, pin_out follows pin_idle. A toggle-mode restart begins at the idle level.
- R12: pin_on_ovf and pin_on_match select which events trigger the pin. An event whose select bit is 0 leaves the pin unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Start (1) or stop (0) counting |
| psc_en | input | 1 | Enable the prescaler |
| psc_exp | input | 4 | Prescale exponent n, divide by 2^n, clamped to 8 |
| reload_en | input | 1 | Load reload_val on overflow instead of zero |
| reload_val | input | 32 | Value loaded on overflow |
| load_en | input | 1 | Write the counter this clock |
| load_val | input | 32 | Value written to the counter |
| cmp_en | input | 1 | Enable compare matching |
| cmp_val | input | 32 | Compare value |
| cap_en | input | 1 | Enable capture |
| cap_sel | input | 2 | Capture transition select |
| cap_pin | input | 1 | Asynchronous capture input |
| pin_on_ovf | input | 1 | Overflow triggers the pin |
| pin_on_match | input | 1 | Match triggers the pin |
| pin_toggle | input | 1 | 1 = toggle mode, 0 = pulse mode |
| pin_idle | input | 1 | Pin level while stopped |
| pin_out | output | 1 | PWM / trigger output |
| count | output | 32 | Current counter value |
| cap_val | output | 32 | Last captured count |
| ovf_evt | output | 1 | Overflow strobe |
| match_evt | output | 1 | Match strobe |
| cap_evt | output | 1 | Capture strobe |

## Verification
The in-line properties assume that every control input other than cap_pin is synchronous to clk and steady around each edge. They also assume that cmp_val and cap_en do not change in the clock before a strobe they qualify. The bench keeps to this by changing controls only just after a rising edge and by leaving compare and capture settings unchanged across each scenario. cap_pin is the only input treated as asynchronous. The bench still changes it away from the edge, so the two-flop latency in the capture checks is exact.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

    typedef enum logic [1:0] {
        OUT_PARK,
        OUT_LO,
        OUT_HI,
        OUT_PULSE
    } out_state_e;

    localparam logic [1:0] EDGE_NONE = 2'b00;
    localparam logic [1:0] EDGE_RISE = 2'b01;
    localparam logic [1:0] EDGE_FALL = 2'b10;
    localparam logic [1:0] EDGE_BOTH = 2'b11;

endpackage

// File: rtl/gpt_prescaler.sv
module gpt_prescaler #(
    parameter int PSC_MAX = 8,
    localparam int EXP_W = $clog2(PSC_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             psc_en,
    input  logic [EXP_W-1:0] psc_exp,
    input  logic             restart,
    output logic             tick
);
    localparam int DIV_W = (PSC_MAX < 1) ? 1 : PSC_MAX;

    logic [EXP_W-1:0] exp_eff;
    logic [DIV_W:0]   full_mask;
    logic [DIV_W-1:0] mask;
    logic [DIV_W-1:0] div_q;

    always_comb begin
        exp_eff   = (psc_exp > EXP_W'(PSC_MAX)) ? EXP_W'(PSC_MAX) : psc_exp;
        full_mask = ((DIV_W + 1)'(1) << exp_eff) - (DIV_W + 1)'(1);
        mask      = full_mask[DIV_W-1:0];
        tick      = run_en && (!psc_en || (div_q == mask));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (!run_en || restart || tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    // R2: divider phase never runs past the selected span while it is counting
    assert_div_span_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && psc_en && !restart && !tick) |=> (div_q == $past(div_q) + 1'b1));

endmodule

// File: rtl/gpt_counter.sv
module gpt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic             reload_en,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             cmp_en,
    input  logic [CNT_W-1:0] cmp_val,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf_hit,
    output logic             match_hit,
    output logic             ovf_evt,
    output logic             match_evt
);
    logic             at_top;
    logic [CNT_W-1:0] cnt_nxt;

    always_comb begin
        at_top    = (cnt == '1);
        cnt_nxt   = at_top ? (reload_en ? reload_val : '0) : cnt + 1'b1;
        ovf_hit   = tick && !load_en && at_top;
        match_hit = tick && !load_en && cmp_en && (cnt_nxt == cmp_val);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            ovf_evt   <= 1'b0;
            match_evt <= 1'b0;
        end else begin
            if (load_en) begin
                cnt <= load_val;
            end else if (tick) begin
                cnt <= cnt_nxt;
            end
            ovf_evt   <= ovf_hit;
            match_evt <= match_hit;
        end
    end

    assert_cnt_incr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load_en && cnt != '1) |=> (cnt == $past(cnt) + 1'b1));

    assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load_en && cnt == '1) |=>
        (ovf_evt && cnt == ($past(reload_en) ? $past(reload_val) : '0)));

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load_en) |=> ($stable(cnt) && !ovf_evt && !match_evt));

    assert_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (cnt == $past(load_val) && !ovf_evt && !match_evt));

    assert_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
        match_evt |-> (cnt == $past(cmp_val) && $past(cmp_en)));

endmodule

// File: rtl/gpt_capture.sv
module gpt_capture #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_pin,
    input  logic             cap_en,
    input  logic [1:0]       cap_sel,
    input  logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cap_val,
    output logic             cap_evt
);
    logic sync1, sync2, sync_prev;
    logic rise, fall, hit;

    always_comb begin
        rise = sync2 && !sync_prev;
        fall = !sync2 && sync_prev;
        hit  = cap_en && ((cap_sel[0] && rise) || (cap_sel[1] && fall));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1     <= 1'b0;
            sync2     <= 1'b0;
            sync_prev <= 1'b0;
            cap_val   <= '0;
            cap_evt   <= 1'b0;
        end else begin
            sync1     <= cap_pin;
            sync2     <= sync1;
            sync_prev <= sync2;
            cap_evt   <= hit;
            if (hit) begin
                cap_val <= cnt;
            end
        end
    end

    assert_cap_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |-> (cap_val == $past(cnt)));

    assert_cap_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |-> ($past(cap_en) && $past(cap_sel) != gpt_pkg::EDGE_NONE));

    assert_cap_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> ($stable(cap_val) && !cap_evt));

endmodule

// File: rtl/gpt_outfsm.sv
module gpt_outfsm
    import gpt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic tick,
    input  logic ovf_hit,
    input  logic match_hit,
    input  logic pin_on_ovf,
    input  logic pin_on_match,
    input  logic pin_toggle,
    input  logic pin_idle,
    output logic pin_out
);
    out_state_e state_q, state_d;
    logic       trig;

    always_comb begin
        trig = (pin_on_ovf && ovf_hit) || (pin_on_match && match_hit);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OUT_PARK;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OUT_PARK: begin
                if (run_en) begin
                    if (pin_toggle) begin
                        state_d = (pin_idle ^ trig) ? OUT_HI : OUT_LO;
                    end else begin
                        state_d = trig ? OUT_PULSE : OUT_LO;
                    end
                end
            end
            OUT_LO: begin
                if (!run_en) begin
                    state_d = OUT_PARK;
                end else if (trig) begin
                    state_d = pin_toggle ? OUT_HI : OUT_PULSE;
                end
            end
            OUT_HI: begin
                if (!run_en) begin
                    state_d = OUT_PARK;
                end else if (pin_toggle) begin
                    state_d = trig ? OUT_LO : OUT_HI;
                end else begin
                    state_d = trig ? OUT_PULSE : OUT_LO;
                end
            end
            OUT_PULSE: begin
                if (!run_en) begin
                    state_d = OUT_PARK;
                end else if (tick) begin
                    state_d = trig ? OUT_PULSE : OUT_LO;
                end
            end
        endcase
    end

    always_comb begin
        unique case (state_q)
            OUT_PARK:  pin_out = pin_idle;
            OUT_LO:    pin_out = 1'b0;
            OUT_HI:    pin_out = 1'b1;
            OUT_PULSE: pin_out = 1'b1;
        endcase
    end

    assert_park_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (state_q == OUT_PARK));

    assert_pulse_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OUT_PULSE && run_en && !tick) |=> (state_q == OUT_PULSE));

    assert_toggle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && pin_toggle && trig && state_q == OUT_LO) |=> (state_q == OUT_HI));

    assert_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && pin_toggle && !trig && state_q == OUT_HI) |=> (state_q == OUT_HI));

endmodule

// File: rtl/gp_timer_core.sv
module gp_timer_core #(
    parameter int CNT_W   = 32,
    parameter int PSC_MAX = 8,
    localparam int EXP_W  = $clog2(PSC_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             psc_en,
    input  logic [EXP_W-1:0] psc_exp,
    input  logic             reload_en,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic             cmp_en,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             cap_en,
    input  logic [1:0]       cap_sel,
    input  logic             cap_pin,
    input  logic             pin_on_ovf,
    input  logic             pin_on_match,
    input  logic             pin_toggle,
    input  logic             pin_idle,
    output logic             pin_out,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] cap_val,
    output logic             ovf_evt,
    output logic             match_evt,
    output logic             cap_evt
);
    logic tick, ovf_hit, match_hit;

    gpt_prescaler #(.PSC_MAX(PSC_MAX)) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_en  (run_en),
        .psc_en  (psc_en),
        .psc_exp (psc_exp),
        .restart (load_en),
        .tick    (tick)
    );

    gpt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .load_en    (load_en),
        .load_val   (load_val),
        .reload_en  (reload_en),
        .reload_val (reload_val),
        .cmp_en     (cmp_en),
        .cmp_val    (cmp_val),
        .cnt        (count),
        .ovf_hit    (ovf_hit),
        .match_hit  (match_hit),
        .ovf_evt    (ovf_evt),
        .match_evt  (match_evt)
    );

    gpt_capture #(.CNT_W(CNT_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_pin (cap_pin),
        .cap_en  (cap_en),
        .cap_sel (cap_sel),
        .cnt     (count),
        .cap_val (cap_val),
        .cap_evt (cap_evt)
    );

    gpt_outfsm u_out (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_en       (run_en),
        .tick         (tick),
        .ovf_hit      (ovf_hit),
        .match_hit    (match_hit),
        .pin_on_ovf   (pin_on_ovf),
        .pin_on_match (pin_on_match),
        .pin_toggle   (pin_toggle),
        .pin_idle     (pin_idle),
        .pin_out      (pin_out)
    );

endmodule

// File: tb/tb_gp_timer_core.sv
module tb_gp_timer_core;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        run_en, psc_en, reload_en, load_en, cmp_en, cap_en, cap_pin;
    logic [3:0]  psc_exp;
    logic [31:0] reload_val, load_val, cmp_val;
    logic [1:0]  cap_sel;
    logic        pin_on_ovf, pin_on_match, pin_toggle, pin_idle;
    logic        pin_out, ovf_evt, match_evt, cap_evt;
    logic [31:0] count, cap_val;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    gp_timer_core dut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .psc_en(psc_en), .psc_exp(psc_exp),
        .reload_en(reload_en), .reload_val(reload_val), .load_en(load_en), .load_val(load_val),
        .cmp_en(cmp_en), .cmp_val(cmp_val), .cap_en(cap_en), .cap_sel(cap_sel), .cap_pin(cap_pin),
        .pin_on_ovf(pin_on_ovf), .pin_on_match(pin_on_match), .pin_toggle(pin_toggle),
        .pin_idle(pin_idle), .pin_out(pin_out), .count(count), .cap_val(cap_val),
        .ovf_evt(ovf_evt), .match_evt(match_evt), .cap_evt(cap_evt)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic write_cnt(input logic [31:0] v);
        load_en  = 1'b1;
        load_val = v;
        step();
        load_en  = 1'b0;
    endtask

    task automatic steps_watch_cap(input int n, output int evts);
        evts = 0;
        for (int i = 0; i < n; i++) begin
            step();
            if (cap_evt) evts++;
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; run_en = 1'b0; psc_en = 1'b0; psc_exp = 4'd0;
        reload_en = 1'b0; reload_val = '0; load_en = 1'b0; load_val = '0;
        cmp_en = 1'b0; cmp_val = '0; cap_en = 1'b0; cap_sel = 2'b00; cap_pin = 1'b0;
        pin_on_ovf = 1'b0; pin_on_match = 1'b0; pin_toggle = 1'b0; pin_idle = 1'b1;
        steps(3);
        chk("R1 count in reset", count, 32'd0);
        chk("R1 pin idle in reset", {31'd0, pin_out}, 32'd1);
        rst_n = 1'b1;
        steps(2);
        chk("R1 count after reset", count, 32'd0);
        chk("R1 cap_val after reset", cap_val, 32'd0);
        chk("R1 strobes after reset", {29'd0, ovf_evt, match_evt, cap_evt}, 32'd0);
        chk("R1 pin after reset", {31'd0, pin_out}, 32'd1);
        pin_idle = 1'b0;
    endtask

    task automatic t_count_stop();
        write_cnt(32'd10);
        chk("R5 write while stopped", count, 32'd10);
        run_en = 1'b1;
        step();
        chk("R2 first tick", count, 32'd11);
        steps(4);
        chk("R2 free run", count, 32'd15);
        run_en = 1'b0;
        step();
        chk("R4 stop holds", count, 32'd15);
        steps(3);
        chk("R4 still held", count, 32'd15);
        chk("R4 no strobes", {30'd0, ovf_evt, match_evt}, 32'd0);
    endtask

    task automatic t_prescale();
        psc_en = 1'b1; psc_exp = 4'd2;
        write_cnt(32'd0);
        run_en = 1'b1;
        steps(3);
        chk("R2 div4 before tick", count, 32'd0);
        step();
        chk("R2 div4 tick", count, 32'd1);
        steps(4);
        chk("R2 div4 second tick", count, 32'd2);
        run_en = 1'b0;
        psc_exp = 4'd12;
        write_cnt(32'd0);
        run_en = 1'b1;
        steps(255);
        chk("R2 clamp to 256 before", count, 32'd0);
        step();
        chk("R2 clamp to 256 tick", count, 32'd1);
        run_en = 1'b0;
        psc_exp = 4'd2;
        write_cnt(32'd40);
        run_en = 1'b1;
        steps(2);
        write_cnt(32'd50);
        chk("R5 write while running", count, 32'd50);
        steps(3);
        chk("R5 phase restarted", count, 32'd50);
        step();
        chk("R5 tick after restart", count, 32'd51);
        run_en = 1'b0; psc_en = 1'b0; psc_exp = 4'd0;
        step();
    endtask

    task automatic t_overflow();
        reload_en = 1'b0;
        write_cnt(32'hFFFF_FFFE);
        run_en = 1'b1;
        step();
        chk("R3 at top", count, 32'hFFFF_FFFF);
        chk("R3 no early ovf", {31'd0, ovf_evt}, 32'd0);
        step();
        chk("R3 wrap to zero", count, 32'd0);
        chk("R3 ovf strobe", {31'd0, ovf_evt}, 32'd1);
        step();
        chk("R3 strobe one cycle", {31'd0, ovf_evt}, 32'd0);
        reload_en = 1'b1; reload_val = 32'h0000_0100;
        write_cnt(32'hFFFF_FFFF);
        chk("R5 write over tick", count, 32'hFFFF_FFFF);
        chk("R5 no ovf on write", {31'd0, ovf_evt}, 32'd0);
        step();
        chk("R3 autoreload", count, 32'h0000_0100);
        chk("R3 ovf with reload", {31'd0, ovf_evt}, 32'd1);
        run_en = 1'b0; reload_en = 1'b0;
        step();
    endtask

    task automatic t_match();
        cmp_en = 1'b1; cmp_val = 32'd20;
        write_cnt(32'd17);
        run_en = 1'b1;
        steps(2);
        chk("R6 no match at 19", {31'd0, match_evt}, 32'd0);
        step();
        chk("R6 count at compare", count, 32'd20);
        chk("R6 match strobe", {31'd0, match_evt}, 32'd1);
        step();
        chk("R6 match one cycle", {31'd0, match_evt}, 32'd0);
        run_en = 1'b0;
        write_cnt(32'd20);
        chk("R6 no match on write", {31'd0, match_evt}, 32'd0);
        cmp_en = 1'b0;
        write_cnt(32'd17);
        run_en = 1'b1;
        steps(3);
        chk("R6 disabled count", count, 32'd20);
        chk("R6 disabled no match", {31'd0, match_evt}, 32'd0);
        run_en = 1'b0;
        step();
    endtask

    task automatic t_pulse();
        pin_toggle = 1'b0; pin_idle = 1'b0; pin_on_match = 1'b1; pin_on_ovf = 1'b0;
        cmp_en = 1'b1; cmp_val = 32'd5; psc_en = 1'b1; psc_exp = 4'd1;
        write_cnt(32'd3);
        run_en = 1'b1;
        steps(3);
        chk("R9 pin low before match", {31'd0, pin_out}, 32'd0);
        step();
        chk("R9 match at 5", {31'd0, match_evt}, 32'd1);
        chk("R9 pulse rises with strobe", {31'd0, pin_out}, 32'd1);
        step();
        chk("R9 pulse held for tick", {31'd0, pin_out}, 32'd1);
        step();
        chk("R9 pulse ends after 2 clocks", {31'd0, pin_out}, 32'd0);
        run_en = 1'b0; psc_en = 1'b0; psc_exp = 4'd0;
        step();
    endtask

    task automatic t_toggle();
        pin_toggle = 1'b1; pin_idle = 1'b0; pin_on_match = 1'b1; pin_on_ovf = 1'b1;
        reload_en = 1'b1; reload_val = 32'hFFFF_FFFC; cmp_en = 1'b1; cmp_val = 32'hFFFF_FFFE;
        write_cnt(32'hFFFF_FFFC);
        run_en = 1'b1;
        step();
        chk("R10 starts low", {31'd0, pin_out}, 32'd0);
        step();
        chk("R10 flip on match", {31'd0, pin_out}, 32'd1);
        step();
        chk("R10 hold between events", {31'd0, pin_out}, 32'd1);
        step();
        chk("R10 flip on overflow", {31'd0, pin_out}, 32'd0);
        steps(2);
        chk("R10 flip again on match", {31'd0, pin_out}, 32'd1);
        run_en = 1'b0;
        step();
        chk("R11 idle low after stop", {31'd0, pin_out}, 32'd0);
        pin_idle = 1'b1;
        #1;
        chk("R11 follows idle level", {31'd0, pin_out}, 32'd1);
        pin_on_match = 1'b0;
        write_cnt(32'hFFFF_FFFC);
        run_en = 1'b1;
        step();
        chk("R11 restart at idle level", {31'd0, pin_out}, 32'd1);
        step();
        chk("R12 match gated off", {31'd0, pin_out}, 32'd1);
        chk("R12 match strobe still seen", {31'd0, match_evt}, 32'd1);
        steps(2);
        chk("R12 overflow still flips", {31'd0, pin_out}, 32'd0);
        run_en = 1'b0; reload_en = 1'b0; cmp_en = 1'b0;
        step();
    endtask

    task automatic t_capture();
        int evts;
        logic [31:0] seen;
        cap_en = 1'b1; cap_sel = 2'b01;
        write_cnt(32'd1000);
        run_en = 1'b1;
        steps(2);
        cap_pin = 1'b1;
        steps(2);
        seen = count;
        step();
        chk("R7 rising capture value", cap_val, seen);
        chk("R7 capture strobe", {31'd0, cap_evt}, 32'd1);
        step();
        chk("R7 strobe one cycle", {31'd0, cap_evt}, 32'd0);
        seen = cap_val;
        cap_pin = 1'b0;
        steps_watch_cap(5, evts);
        chk("R7 falling ignored in rising mode", cap_val, seen);
        chk("R7 no strobe on falling", evts, 0);
        cap_sel = 2'b10;
        cap_pin = 1'b1;
        steps_watch_cap(5, evts);
        chk("R7 rising ignored in falling mode", evts, 0);
        cap_pin = 1'b0;
        steps(2);
        seen = count;
        step();
        chk("R7 falling capture value", cap_val, seen);
        cap_sel = 2'b11;
        cap_pin = 1'b1;
        steps_watch_cap(5, evts);
        cap_pin = 1'b0;
        steps_watch_cap(5, evts);
        chk("R7 both edges capture", {31'd0, cap_evt}, 32'd0);
        chk("R7 both mode falling strobe", evts, 1);
        cap_sel = 2'b00;
        seen = cap_val;
        cap_pin = 1'b1;
        steps_watch_cap(5, evts);
        chk("R8 select none no strobe", evts, 0);
        chk("R8 select none value kept", cap_val, seen);
        cap_sel = 2'b11; cap_en = 1'b0;
        cap_pin = 1'b0;
        steps_watch_cap(5, evts);
        chk("R8 disabled no strobe", evts, 0);
        chk("R8 disabled value kept", cap_val, seen);
        run_en = 1'b0;
        step();
    endtask

    initial begin
        #(5.0 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_count_stop();
        t_prescale();
        t_overflow();
        t_match();
        t_pulse();
        t_toggle();
        t_capture();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule